// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block sits on the host side of an 8-bit parallel NOR flash. A client hands it one request at a time through a start pulse with an operation code, a target address, a data byte and a poll limit. The block turns that request into the right series of flash bus cycles. It drives chip enable, output enable and write enable, all active low, together with a 17-bit address and a data bus. The data bus is split into an output path, an output-enable and an input path.

Requests that change the array are preceded by the unlock writes the device expects. For program and sector erase, the block then reads the device's status byte again and again, always at the address of the final command write. It stops when the status shows completion, when the device reports an internal failure, or when the poll budget runs out. After a failure or a timeout it sends a single reset write to return the device to array-read mode. A one-cycle done pulse carries the result code and any byte that was read.

Top module: `flash_cmd_seq`

## Requirements
- R1: Each bus cycle starts with chip enable, output enable and write enable all high. Chip enable falls first. The address is driven in the following cycle. Exactly one strobe (output enable for a read, write enable for a write) is then held low for STROBE_CYC cycles, with the address held steady. The strobe rises at least one cycle before chip enable rises.
- R2: Output enable and write enable are never low together. `fl_dq_oe` is asserted only in write cycles, never while output enable is low.
- R3: Operation code 0 (reset) writes three cycles, as address/data pairs: 5555/AA, 2AAA/55, 5555/F0. It finishes with error code 0.
- R4: Operation code 1 writes 5555/AA, 2AAA/55, 5555/90, then reads address 0; `rd_data` returns the manufacturer code (01 from a conforming device). Operation code 2 does the same but reads address 1, returning the device code (20).
- R5: Operation code 3 (program) writes 5555/AA, 2AAA/55, 5555/A0, then writes `req_data` to `req_addr`.
- R6: Operation code 4 (sector erase) writes 5555/AA, 2AAA/55, 5555/80, 5555/AA, 2AAA/55, then 30 to the sector base. The sector base is `req_addr[16:14]` followed by fourteen zero bits.
- R7: After program or erase, status reads go to the address of the final command write. The operation completes with error 0 as soon as status bit 7 equals `req_data[7]` (program) or equals 1 (erase). This completion test takes priority over the failure bit.
- R8: If a status read is not complete and has bit 5 set, the block writes 5555/F0 and finishes with error code 1.
- R9: A single operation issues at most max(`poll_limit`,1) status reads. If none of them completes or fails, the block writes 5555/F0 and finishes with error code 2.
- R10: Operation code 5 (plain read) performs exactly one read cycle at `req_addr`, makes no write, and returns the byte on `rd_data`.
- R11: `busy` is high from the cycle after a request is accepted until `done` pulses. `done` lasts one cycle, in the first cycle with `busy` low. `req_valid` is ignored while `busy` is high.
- R12: While `rst` is high and after it falls: all three strobes are high, `fl_dq_oe`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start pulse for a request, taken when idle |
| req_op | input | 3 | Operation code (0 reset, 1 maker ID, 2 device ID, 3 program, 4 erase, 5 read) |
| req_addr | input | 17 | Target address |
| req_data | input | 8 | Byte to program |
| poll_limit | input | 16 | Maximum status reads per operation |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | Result: 0 ok, 1 device failure, 2 timeout |
| rd_data | output | 8 | Byte from the last read-type request |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | 17 | Flash address |
| fl_dq_out | output | 8 | Data driven toward the flash |
| fl_dq_oe | output | 1 | Drive enable for `fl_dq_out` |
| fl_dq_in | input | 8 | Data returned by the flash |

## Verification
A sequencer stuck on the wrong step index shows up right away as a wrong address/data pair in the write log kept by the flash model. That pair appears within the first bus cycle after the fault, about six clocks. A wrong poll decision shows up in the status read count and the result code when `done` arrives. A strobe ordering fault breaks the pin relations in the very cycle it happens. Both the behavioural flash in the bench and the properties on the bus stage watch those relations.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  localparam int FL_AW  = 17;
  localparam int FL_DW  = 8;
  localparam int SECT_W = 3;
  localparam int STEP_W = 3;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_MFR_ID = 3'd1,
    OP_DEV_ID = 3'd2,
    OP_PROG   = 3'd3,
    OP_ERASE  = 3'd4,
    OP_READ   = 3'd5
  } fl_op_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_DEVICE  = 2'd1,
    ERR_TIMEOUT = 2'd2
  } fl_err_e;

  typedef struct packed {
    logic             rd;
    logic [FL_AW-1:0] addr;
    logic [FL_DW-1:0] data;
    logic             last;
  } fl_step_t;

  localparam logic [FL_AW-1:0] UNLOCK_A = 17'h05555;
  localparam logic [FL_AW-1:0] UNLOCK_B = 17'h02AAA;
endpackage

// File: rtl/flash_cmd_rom.sv
module flash_cmd_rom
  import flash_seq_pkg::*;
(
  input  fl_op_e            op,
  input  logic [STEP_W-1:0] idx,
  input  logic [FL_AW-1:0]  tgt_addr,
  input  logic [FL_DW-1:0]  tgt_data,
  output fl_step_t          step
);
  logic [FL_DW-1:0] cmd_byte;

  always_comb begin
    case (op)
      OP_RESET: cmd_byte = 8'hF0;
      OP_PROG:  cmd_byte = 8'hA0;
      default:  cmd_byte = 8'h90;
    endcase
  end

  always_comb begin
    step = '{rd: 1'b0, addr: UNLOCK_A, data: 8'hAA, last: 1'b0};
    case (op)
      OP_ERASE: begin
        case (idx)
          3'd1, 3'd4: begin step.addr = UNLOCK_B; step.data = 8'h55; end
          3'd2:       step.data = 8'h80;
          3'd5: begin
            step.addr = {tgt_addr[FL_AW-1 -: SECT_W], {(FL_AW-SECT_W){1'b0}}};
            step.data = 8'h30;
            step.last = 1'b1;
          end
          default: ;
        endcase
      end
      OP_READ: begin
        step.rd   = 1'b1;
        step.addr = tgt_addr;
        step.last = 1'b1;
      end
      default: begin
        case (idx)
          3'd0: ;
          3'd1: begin step.addr = UNLOCK_B; step.data = 8'h55; end
          3'd2: begin step.data = cmd_byte; step.last = (op == OP_RESET); end
          default: begin
            step.last = 1'b1;
            if (op == OP_PROG) begin
              step.addr = tgt_addr;
              step.data = tgt_data;
            end else begin
              step.rd   = 1'b1;
              step.addr = {{(FL_AW-1){1'b0}}, (op == OP_DEV_ID)};
            end
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/flash_bus_if.sv
module flash_bus_if
  import flash_seq_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  fl_step_t         req,
  output logic             cyc_done,
  output logic [FL_DW-1:0] rdata,
  output logic             ce_n,
  output logic             oe_n,
  output logic             we_n,
  output logic [FL_AW-1:0] addr,
  output logic [FL_DW-1:0] dq_out,
  output logic             dq_oe,
  input  logic [FL_DW-1:0] dq_in
);
  localparam int CNT_W = $clog2(STROBE_CYC) + 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

  typedef enum logic [2:0] {B_IDLE, B_CE, B_ADDR, B_STB, B_REL} ph_e;
  ph_e              ph;
  logic [CNT_W-1:0] cnt;
  fl_step_t         held;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= B_IDLE;
      cnt      <= '0;
      held     <= '0;
      cyc_done <= 1'b0;
      rdata    <= '0;
      ce_n     <= 1'b1;
      oe_n     <= 1'b1;
      we_n     <= 1'b1;
      addr     <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (ph)
        B_IDLE: if (start) begin
          held <= req;
          ce_n <= 1'b0;
          ph   <= B_CE;
        end
        B_CE: begin
          addr   <= held.addr;
          dq_out <= held.data;
          dq_oe  <= !held.rd;
          ph     <= B_ADDR;
        end
        B_ADDR: begin
          if (held.rd) oe_n <= 1'b0;
          else         we_n <= 1'b0;
          cnt <= '0;
          ph  <= B_STB;
        end
        B_STB: begin
          if (cnt == CNT_LAST) begin
            oe_n <= 1'b1;
            we_n <= 1'b1;
            if (held.rd) rdata <= dq_in;
            ph <= B_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          ce_n     <= 1'b1;
          dq_oe    <= 1'b0;
          cyc_done <= 1'b1;
          ph       <= B_IDLE;
        end
      endcase
    end
  end

  // R2
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!oe_n && !we_n));
  // R1
  stb_in_ce_chk: assert property (@(posedge clk) disable iff (rst) (!oe_n || !we_n) |-> !ce_n);
  // R1
  ce_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(ce_n) |-> ($past(oe_n) && $past(we_n)));
  // R1
  stb_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n || !we_n) |=> ((oe_n && we_n) || $stable(addr)));
  // R2
  dq_drive_chk: assert property (@(posedge clk) disable iff (rst) dq_oe |-> oe_n);
  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (rst) start |-> (ph == B_IDLE));
endmodule

// File: rtl/flash_poll_eval.sv
module flash_poll_eval
  import flash_seq_pkg::*;
(
  input  logic [FL_DW-1:0] status,
  input  logic             is_erase,
  input  logic             want_b7,
  output logic             complete,
  output logic             failed
);
  assign complete = is_erase ? status[7] : (status[7] == want_b7);
  assign failed   = !complete && status[5];
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int STROBE_CYC = 2,
  parameter int POLL_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [FL_AW-1:0]  req_addr,
  input  logic [FL_DW-1:0]  req_data,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              busy,
  output logic              done,
  output logic [1:0]        done_err,
  output logic [FL_DW-1:0]  rd_data,
  output logic              fl_ce_n,
  output logic              fl_oe_n,
  output logic              fl_we_n,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [FL_DW-1:0]  fl_dq_out,
  output logic              fl_dq_oe,
  input  logic [FL_DW-1:0]  fl_dq_in
);
  localparam logic [POLL_W:0] POLL_ONE = (POLL_W+1)'(1);

  typedef enum logic [1:0] {S_IDLE, S_SEQ, S_POLL, S_ABORT} st_e;
  st_e               state;
  fl_op_e            op_q;
  logic [FL_AW-1:0]  addr_q, poll_addr;
  logic [FL_DW-1:0]  data_q;
  logic [POLL_W-1:0] lim_q, polls;
  logic [STEP_W-1:0] idx;
  fl_err_e           err_q;
  logic              bus_start, bus_done;
  logic [FL_DW-1:0]  bus_rdata;
  fl_step_t          rom_step, bus_req;
  logic              st_complete, st_failed, budget_out;

  flash_cmd_rom rom_i (
    .op(op_q), .idx(idx), .tgt_addr(addr_q), .tgt_data(data_q), .step(rom_step)
  );

  flash_poll_eval eval_i (
    .status(bus_rdata), .is_erase(op_q == OP_ERASE), .want_b7(data_q[7]),
    .complete(st_complete), .failed(st_failed)
  );

  always_comb begin
    case (state)
      S_POLL:  bus_req = '{rd: 1'b1, addr: poll_addr, data: 8'h00, last: 1'b1};
      S_ABORT: bus_req = '{rd: 1'b0, addr: UNLOCK_A, data: 8'hF0, last: 1'b1};
      default: bus_req = rom_step;
    endcase
  end

  flash_bus_if #(.STROBE_CYC(STROBE_CYC)) bus_i (
    .clk(clk), .rst(rst), .start(bus_start), .req(bus_req),
    .cyc_done(bus_done), .rdata(bus_rdata),
    .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .addr(fl_addr),
    .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
  );

  assign budget_out = ({1'b0, polls} + POLL_ONE) >= {1'b0, lim_q};
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      op_q      <= OP_RESET;
      addr_q    <= '0;
      data_q    <= '0;
      lim_q     <= '0;
      polls     <= '0;
      idx       <= '0;
      poll_addr <= '0;
      err_q     <= ERR_NONE;
      bus_start <= 1'b0;
      done      <= 1'b0;
      done_err  <= ERR_NONE;
      rd_data   <= '0;
    end else begin
      bus_start <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q      <= fl_op_e'(req_op);
          addr_q    <= req_addr;
          data_q    <= req_data;
          lim_q     <= poll_limit;
          polls     <= '0;
          idx       <= '0;
          bus_start <= 1'b1;
          state     <= S_SEQ;
        end
        S_SEQ: if (bus_done) begin
          if (!rom_step.last) begin
            idx       <= idx + 1'b1;
            bus_start <= 1'b1;
          end else begin
            if (rom_step.rd) rd_data <= bus_rdata;
            if (op_q == OP_PROG || op_q == OP_ERASE) begin
              poll_addr <= rom_step.addr;
              bus_start <= 1'b1;
              state     <= S_POLL;
            end else begin
              done     <= 1'b1;
              done_err <= ERR_NONE;
              state    <= S_IDLE;
            end
          end
        end
        S_POLL: if (bus_done) begin
          if (st_complete) begin
            done     <= 1'b1;
            done_err <= ERR_NONE;
            state    <= S_IDLE;
          end else if (st_failed || budget_out) begin
            err_q     <= st_failed ? ERR_DEVICE : ERR_TIMEOUT;
            bus_start <= 1'b1;
            state     <= S_ABORT;
          end else begin
            polls     <= polls + 1'b1;
            bus_start <= 1'b1;
          end
        end
        default: if (bus_done) begin
          done     <= 1'b1;
          done_err <= err_q;
          state    <= S_IDLE;
        end
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R9
  poll_budget_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_POLL) |-> (({1'b0, polls} < {1'b0, lim_q}) || (polls == '0)));
endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, req_valid, busy, done;
  logic [2:0]  req_op;
  logic [16:0] req_addr, fl_addr;
  logic [7:0]  req_data, rd_data, fl_dq_out, fl_dq_in;
  logic [15:0] poll_limit;
  logic [1:0]  done_err;
  logic        fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;

  flash_cmd_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .poll_limit(poll_limit), .busy(busy), .done(done),
    .done_err(done_err), .rd_data(rd_data), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in)
  );

  // ---------------- behavioural flash ----------------
  int          nw = 0, nr = 0, viol = 0, busy_left = 0, mode = 0;
  logic [16:0] wa [128];
  logic [7:0]  wd [128];
  logic [16:0] last_ra = '0, stb_a = '0, pa = '0;
  logic [7:0]  pd = '0, mval;
  logic        tog = 1'b0, pv = 1'b0, ev = 1'b0, p_ce = 1'b1, p_oe = 1'b1, p_we = 1'b1;
  logic [2:0]  esa = '0;
  int          cfg_busy = 0;
  logic        cfg_fail = 1'b0;

  always_comb begin
    if (mode == 1)                          mval = fl_addr[0] ? 8'h20 : 8'h01;
    else if (mode >= 2 && busy_left != 0)   mval = (mode == 2) ? {~pd[7], tog, cfg_fail, 5'b0}
                                                               : {1'b0, tog, cfg_fail, 1'b1, 4'b0};
    else if (mode == 2)                     mval = pd;
    else if (mode == 3)                     mval = 8'hFF;
    else if (ev && fl_addr[16:14] == esa)   mval = 8'hFF;
    else if (pv && fl_addr == pa)           mval = pd;
    else                                    mval = fl_addr[7:0] ^ 8'h5A;
  end
  assign fl_dq_in = (!fl_ce_n && !fl_oe_n) ? mval : 8'h00;

  always @(negedge clk) begin
    if (!fl_oe_n && !fl_we_n) viol++;
    if ((!fl_oe_n || !fl_we_n) && fl_ce_n) viol++;
    if (fl_dq_oe && !fl_oe_n) viol++;
    if (fl_ce_n && !p_ce && !(p_oe && p_we)) viol++;
    if ((!fl_oe_n && p_oe) || (!fl_we_n && p_we)) begin
      if (p_ce) viol++;
      stb_a = fl_addr;
    end
    if (!fl_oe_n || !fl_we_n) if (fl_addr != stb_a) viol++;
    if (fl_we_n && !p_we) begin
      if (fl_dq_out == 8'hF0) mode = 0;
      else if (nw >= 2 && fl_dq_out == 8'h90 && wd[nw-1] == 8'h55 && wd[nw-2] == 8'hAA) mode = 1;
      else if (nw >= 3 && wd[nw-1] == 8'hA0 && wd[nw-2] == 8'h55 && wd[nw-3] == 8'hAA) begin
        pd = fl_dq_out; pa = fl_addr; pv = 1'b0; mode = 2; busy_left = cfg_busy;
      end else if (nw >= 5 && fl_dq_out == 8'h30 && wd[nw-1] == 8'h55 && wd[nw-3] == 8'h80) begin
        esa = fl_addr[16:14]; ev = 1'b0; mode = 3; busy_left = cfg_busy;
      end
      wa[nw] = fl_addr; wd[nw] = fl_dq_out; nw++;
    end
    if (fl_oe_n && !p_oe) begin
      nr++; last_ra = stb_a;
      if (mode >= 2) begin
        if (busy_left == 0) begin
          if (mode == 2) pv = 1'b1; else ev = 1'b1;
          mode = 0;
        end else begin
          busy_left--; tog = ~tog;
        end
      end
    end
    p_ce = fl_ce_n; p_oe = fl_oe_n; p_we = fl_we_n;
  end

  // ---------------- checking ----------------
  int tests = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [16:0] addr;
    logic [7:0]  data;
    logic [7:0]  busy;
    logic        fail;
    logic [15:0] lim;
    logic [1:0]  err;
    logic [7:0]  rd;
    logic [7:0]  nrd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 17'h00000, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h00, 8'd0},
    '{3'd1, 17'h00000, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h01, 8'd1},
    '{3'd2, 17'h00000, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h20, 8'd1},
    '{3'd0, 17'h00000, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h00, 8'd0},
    '{3'd5, 17'h01234, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h6E, 8'd1},
    '{3'd3, 17'h0ABCD, 8'h3C, 8'd3,   1'b0, 16'd10, 2'd0, 8'h00, 8'd4},
    '{3'd5, 17'h0ABCD, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h3C, 8'd1},
    '{3'd3, 17'h12345, 8'hC5, 8'd2,   1'b0, 16'd10, 2'd0, 8'h00, 8'd3},
    '{3'd5, 17'h12345, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'hC5, 8'd1},
    '{3'd4, 17'h1F123, 8'h00, 8'd5,   1'b0, 16'd20, 2'd0, 8'h00, 8'd6},
    '{3'd5, 17'h1D00F, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'hFF, 8'd1},
    '{3'd3, 17'h00100, 8'h11, 8'd4,   1'b1, 16'd20, 2'd1, 8'h00, 8'd1},
    '{3'd3, 17'h00200, 8'h22, 8'd200, 1'b0, 16'd5,  2'd2, 8'h00, 8'd5},
    '{3'd3, 17'h00300, 8'h33, 8'd200, 1'b0, 16'd0,  2'd2, 8'h00, 8'd1},
    '{3'd4, 17'h04000, 8'h00, 8'd3,   1'b1, 16'd20, 2'd1, 8'h00, 8'd1},
    '{3'd3, 17'h00400, 8'h44, 8'd4,   1'b0, 16'd5,  2'd0, 8'h00, 8'd5},
    '{3'd5, 17'h00400, 8'h00, 8'd0,   1'b0, 16'd1,  2'd0, 8'h44, 8'd1}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R10";
    endcase
  endfunction

  logic [1:0] got_err;
  logic [7:0] got_rd;

  task automatic issue(input vec_t v, output bit ok);
    int guard;
    @(negedge clk);
    cfg_busy = int'(v.busy); cfg_fail = v.fail;
    req_op = v.op; req_addr = v.addr; req_data = v.data; poll_limit = v.lim;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    ok = done;
    got_err = done_err; got_rd = rd_data;
    @(negedge clk);
    check(done == 1'b0, "R11 done width", done, 0);
  endtask

  task automatic run_vec(input vec_t v);
    logic [16:0] ea [8];
    logic [7:0]  ed [8];
    logic [16:0] exp_ra;
    int n = 0, bw = nw, br = nr;
    bit ok, wok;
    if (v.op != 3'd5) begin
      ea[n] = 17'h05555; ed[n] = 8'hAA; n++;
      ea[n] = 17'h02AAA; ed[n] = 8'h55; n++;
      case (v.op)
        3'd0: begin ea[n] = 17'h05555; ed[n] = 8'hF0; n++; end
        3'd1, 3'd2: begin ea[n] = 17'h05555; ed[n] = 8'h90; n++; end
        3'd3: begin ea[n] = 17'h05555; ed[n] = 8'hA0; n++; ea[n] = v.addr; ed[n] = v.data; n++; end
        default: begin
          ea[n] = 17'h05555; ed[n] = 8'h80; n++;
          ea[n] = 17'h05555; ed[n] = 8'hAA; n++;
          ea[n] = 17'h02AAA; ed[n] = 8'h55; n++;
          ea[n] = {v.addr[16:14], 14'h0}; ed[n] = 8'h30; n++;
        end
      endcase
    end
    if (v.err != 2'd0) begin ea[n] = 17'h05555; ed[n] = 8'hF0; n++; end
    issue(v, ok);
    check(ok, "R11 done seen", ok, 1);
    wok = ((nw - bw) == n);
    for (int k = 0; k < 8; k++)
      if (wok && k < n) wok = (wa[bw+k] == ea[k]) && (wd[bw+k] == ed[k]);
    check(wok, {tag_of(v.op), " write sequence"}, nw - bw, n);
    if (v.op == 3'd3 || v.op == 3'd4) begin
      check(got_err == v.err, (v.err == 2'd0) ? "R7 result" : (v.err == 2'd1) ? "R8 result" : "R9 result",
            got_err, v.err);
      check((nr - br) == int'(v.nrd), (v.err == 2'd2) ? "R9 poll count" : "R7 poll count", nr - br, v.nrd);
    end else begin
      check(got_err == 2'd0, {tag_of(v.op), " result"}, got_err, 0);
      check((nr - br) == int'(v.nrd), {tag_of(v.op), " read count"}, nr - br, v.nrd);
    end
    if (v.op == 3'd1 || v.op == 3'd2 || v.op == 3'd5)
      check(got_rd == v.rd, {tag_of(v.op), " read data"}, got_rd, v.rd);
    if (v.nrd != 8'd0) begin
      case (v.op)
        3'd1: exp_ra = 17'h0;
        3'd2: exp_ra = 17'h1;
        3'd4: exp_ra = {v.addr[16:14], 14'h0};
        default: exp_ra = v.addr;
      endcase
      check(last_ra == exp_ra, "R7 read address", last_ra, exp_ra);
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int bw;
    bit ok;
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0; poll_limit = '0;
    repeat (4) @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n, "R12 strobes high in reset", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
    check(!busy && !done && !fl_dq_oe, "R12 idle outputs in reset", {busy, done, fl_dq_oe}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(fl_ce_n && fl_oe_n && fl_we_n && !busy, "R12 idle after reset", {fl_ce_n, fl_oe_n, fl_we_n, busy}, 14);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R11: a second request during busy is dropped
    bw = nw;
    @(negedge clk);
    req_op = 3'd0; req_addr = '0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    req_op = 3'd3; req_addr = 17'h00777; req_data = 8'h12; poll_limit = 16'd4; req_valid = 1'b1;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    for (int g = 0; g < 2000 && !ok; g++) begin @(negedge clk); ok = done; end
    check(ok, "R11 first request done", ok, 1);
    repeat (40) @(negedge clk);
    check((nw - bw) == 3, "R11 busy request ignored", nw - bw, 3);
    check(!busy, "R11 idle after ignore", busy, 0);

    check(viol == 0, "R1 R2 bus protocol", viol, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule